// File: doc/BRIEF.md
# Video Plane Line Fetch Generator

This block produces the stream of 64-bit word read addresses needed to fetch one video plane from memory for a memory-to-memory scaler. Software supplies the source window width in pixels, the height in lines, the bytes per component, the line pitch, and two base addresses. The first base serves the first interlaced field and the second base serves the other. A field select input chooses between them. When a frame is started, the block latches this setup, works out how many 64-bit words cover one line, and then issues one address per request/grant transfer, line after line.

The low three bits of the selected base mark where the leftmost component sits inside the first 64-bit word. That offset is counted in the per-line word count and is reported to the downstream unpacker. A reverse input makes each line run from its highest word down to its lowest, which lets the scaler mirror the picture horizontally. A setup whose offset is not a whole number of components is flagged, and the block refuses to start on it. When the last word of the last line has been granted, the block drops its request and gives a one-cycle completion pulse.

Top module: `vplane_fetch_gen`

## Requirements
- R1: After reset, `req`, `busy` and `done` are low.
- R2: Each line issues exactly ceil((off + width_px × comp_bytes) / 8) word addresses, where off is bits [2:0] of the selected base.
- R3: Line n (counting from 0) begins at (selected base + n × pitch) with bits [2:0] cleared. Lines follow each other in increasing n.
- R4: With `reverse` low, the first address of a line is its word-aligned start, and each following address is 8 higher.
- R5: With `reverse` high, the first address of a line is its last word, and each following address is 8 lower.
- R6: `field_sel` = 0 selects `base_a` and `field_sel` = 1 selects `base_b`. `lead_offset` shows bits [2:0] of the selected base from the cycle after an accepted start, and it holds that value for the whole frame.
- R7: `align_err` is high, from the present inputs, when `comp_bytes` is 0 or when the selected offset is not a multiple of `comp_bytes`. A start while `align_err` is high is ignored: `busy` and `req` stay low.
- R8: `done` is high for exactly one cycle, in the cycle after the grant of the last word of the last line. In that cycle `req` and `busy` are low.
- R9: A transfer takes place only when `req` and `gnt` are both high at a clock edge. While `gnt` is low, `req` stays high and `addr` does not change.
- R10: A start is ignored while `busy` is high. A start is also ignored when `width_px` or `height_ln` is zero. Once a frame is accepted, later changes to the setup inputs do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame with the current setup |
| field_sel | input | 1 | 0 selects base_a, 1 selects base_b |
| reverse | input | 1 | Fetch each line from its last word down to its first |
| width_px | input | PIX_W | Window width in pixels |
| height_ln | input | LINE_W | Window height in lines |
| comp_bytes | input | 3 | Bytes per component |
| pitch | input | ADDR_W | Byte distance between consecutive lines |
| base_a | input | ADDR_W | Byte address of line 0 for the first field |
| base_b | input | ADDR_W | Byte address of line 0 for the second field |
| req | output | 1 | A word address is offered |
| addr | output | ADDR_W | 64-bit-aligned word address |
| gnt | input | 1 | The offered address is taken at this clock edge |
| lead_offset | output | 3 | Byte offset of the leftmost component in the first word |
| align_err | output | 1 | The current setup has a misaligned offset or a zero component size |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the final grant |

## Verification
Two events can fall in the same clock edge. A grant that completes a line also moves the line base forward by one pitch. A grant that completes the last line also ends the frame. Both are provoked with one-word lines under a grant held high every cycle, so every grant is the last word of its line. In that run, each address must equal the next line's aligned start, and `done` must appear exactly one cycle after the final grant. Stalled grants, and a start pulse inside a stall, are mixed into other frames to show that the sequence only advances on a real transfer.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  // Number of 64-bit words that cover one line, counting the leading byte offset.
  function automatic logic [31:0] span_words(input logic [2:0] off,
                                             input logic [31:0] width,
                                             input logic [2:0] cbytes);
    logic [31:0] span;
    span = {29'd0, off} + width * {29'd0, cbytes};
    return (span + 32'd7) >> 3;
  endfunction

  // Offset is illegal if it is not a whole number of components.
  function automatic logic offset_bad(input logic [2:0] off, input logic [2:0] cbytes);
    if (cbytes == 3'd0) return 1'b1;
    return (off % cbytes) != 3'd0;
  endfunction

  // Word address of the idx-th fetch of a line.
  function automatic logic [31:0] fetch_addr(input logic [31:0] line_base,
                                             input logic [31:0] idx,
                                             input logic [31:0] words,
                                             input logic        rev);
    logic [31:0] k;
    k = rev ? (words - 32'd1 - idx) : idx;
    return (line_base & ~32'h7) + (k << 3);
  endfunction

endpackage

// File: rtl/vpf_geom.sv
module vpf_geom
  import vpf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PIX_W  = 12,
  parameter int WCNT_W = PIX_W + 1
) (
  input  logic              field_sel,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [PIX_W-1:0]  width_px,
  input  logic [2:0]        comp_bytes,
  output logic [ADDR_W-1:0] sel_base,
  output logic [2:0]        offset,
  output logic [WCNT_W-1:0] words,
  output logic              misaligned
);
  always_comb begin
    sel_base   = field_sel ? base_b : base_a;
    offset     = sel_base[2:0];
    words      = WCNT_W'(span_words(offset, 32'(width_px), comp_bytes));
    misaligned = offset_bad(offset, comp_bytes);
  end
endmodule

// File: rtl/vpf_step_ctr.sv
module vpf_step_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         last
);
  assign last = (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= last ? '0 : cnt + W'(1);
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < limit)); // R2
endmodule

// File: rtl/vpf_line_base.sv
module vpf_line_base #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic [ADDR_W-1:0] pitch,
  output logic [ADDR_W-1:0] line_base
);
  always_ff @(posedge clk) begin
    if (!rst_n)    line_base <= '0;
    else if (load) line_base <= load_val;
    else if (step) line_base <= line_base + pitch;
  end

  AST_LINE_PITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (line_base == $past(line_base) + $past(pitch))); // R3
endmodule

// File: rtl/vplane_fetch_gen.sv
module vplane_fetch_gen
  import vpf_pkg::*;
#(
  parameter int ADDR_W = 32,   // at most 32
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              field_sel,
  input  logic              reverse,
  input  logic [PIX_W-1:0]  width_px,
  input  logic [LINE_W-1:0] height_ln,
  input  logic [2:0]        comp_bytes,
  input  logic [ADDR_W-1:0] pitch,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  input  logic              gnt,
  output logic [2:0]        lead_offset,
  output logic              align_err,
  output logic              busy,
  output logic              done
);
  localparam int WCNT_W = PIX_W + 1;

  logic [ADDR_W-1:0] sel_base;
  logic [2:0]        offset;
  logic [WCNT_W-1:0] words;
  logic              misaligned;

  vpf_geom #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .WCNT_W(WCNT_W)) geom_i (
    .field_sel (field_sel),
    .base_a    (base_a),
    .base_b    (base_b),
    .width_px  (width_px),
    .comp_bytes(comp_bytes),
    .sel_base  (sel_base),
    .offset    (offset),
    .words     (words),
    .misaligned(misaligned)
  );

  // Latched frame setup
  logic              busy_q, done_q, rev_q;
  logic [WCNT_W-1:0] words_q;
  logic [LINE_W-1:0] height_q;
  logic [ADDR_W-1:0] pitch_q;
  logic [2:0]        off_q;

  // Named events
  logic go, fire, line_end, frame_end;
  logic w_last, l_last;
  logic [WCNT_W-1:0] w_cnt;
  logic [LINE_W-1:0] l_cnt;
  logic [ADDR_W-1:0] line_base;

  assign go        = start && !busy_q && !misaligned &&
                     (width_px != '0) && (height_ln != '0);
  assign fire      = busy_q && gnt;
  assign line_end  = fire && w_last;
  assign frame_end = line_end && l_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rev_q    <= 1'b0;
      words_q  <= '0;
      height_q <= '0;
      pitch_q  <= '0;
      off_q    <= '0;
    end else begin
      done_q <= frame_end;
      if (go) begin
        busy_q   <= 1'b1;
        rev_q    <= reverse;
        words_q  <= words;
        height_q <= height_ln;
        pitch_q  <= pitch;
        off_q    <= offset;
      end else if (frame_end) begin
        busy_q <= 1'b0;
      end
    end
  end

  vpf_step_ctr #(.W(WCNT_W)) word_ctr_i (
    .clk(clk), .rst_n(rst_n), .active(busy_q), .clear(go), .step(fire),
    .limit(words_q), .cnt(w_cnt), .last(w_last)
  );

  vpf_step_ctr #(.W(LINE_W)) line_ctr_i (
    .clk(clk), .rst_n(rst_n), .active(busy_q), .clear(go), .step(line_end),
    .limit(height_q), .cnt(l_cnt), .last(l_last)
  );

  vpf_line_base #(.ADDR_W(ADDR_W)) line_base_i (
    .clk(clk), .rst_n(rst_n), .load(go), .load_val(sel_base),
    .step(line_end), .pitch(pitch_q), .line_base(line_base)
  );

  assign addr        = ADDR_W'(fetch_addr(32'(line_base), 32'(w_cnt), 32'(words_q), rev_q));
  assign req         = busy_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign lead_offset = off_q;
  assign align_err   = misaligned;

  AST_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !w_last && !rev_q) |=> (addr == $past(addr) + ADDR_W'(8))); // R4
  AST_REV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !w_last && rev_q) |=> (addr == $past(addr) - ADDR_W'(8))); // R5
  AST_HOLD_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |=> (req && $stable(addr))); // R9
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req && !busy)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && align_err) |=> !req); // R7
  AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lead_offset)); // R6
  AST_LINES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (l_cnt < height_q)); // R3
endmodule

// File: tb/vplane_fetch_gen_tb_top.sv
module vplane_fetch_gen_tb_top;
  localparam int ADDR_W = 32;
  localparam int PIX_W  = 12;
  localparam int LINE_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, field_sel = 1'b0, reverse = 1'b0, gnt = 1'b0;
  logic [PIX_W-1:0]  width_px = '0;
  logic [LINE_W-1:0] height_ln = '0;
  logic [2:0]        comp_bytes = 3'd1;
  logic [ADDR_W-1:0] pitch = '0, base_a = '0, base_b = '0;
  logic              req, align_err, busy, done;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        lead_offset;

  int n_checks = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  vplane_fetch_gen #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .LINE_W(LINE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .field_sel(field_sel), .reverse(reverse),
    .width_px(width_px), .height_ln(height_ln), .comp_bytes(comp_bytes), .pitch(pitch),
    .base_a(base_a), .base_b(base_b), .req(req), .addr(addr), .gnt(gnt),
    .lead_offset(lead_offset), .align_err(align_err), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one frame. stall: hold gnt low before every other word.
  // poke: pulse start during the first stall.
  task automatic run_frame(input logic [31:0] ba, input logic [31:0] bb, input logic fs,
                           input logic rev, input int w, input int h, input int cb,
                           input logic [31:0] pt, input bit stall, input bit poke);
    logic [31:0] sel, lb, wb, exp_a;
    int off, span, nw;
    bit poked;
    poked = 0;
    sel  = fs ? bb : ba;
    off  = int'(sel & 32'h7);
    span = off + w * cb;
    nw   = span / 8 + ((span % 8) != 0 ? 1 : 0);
    @(negedge clk);
    base_a = ba; base_b = bb; field_sel = fs; reverse = rev;
    width_px = PIX_W'(w); height_ln = LINE_W'(h); comp_bytes = 3'(cb); pitch = pt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble setup: the frame must not notice (R10)
    base_a = 32'hDEAD_BEE0; base_b = 32'h1234_5670; width_px = PIX_W'(3); pitch = 32'h10;
    reverse = ~rev; field_sel = ~fs;
    chk("R6 lead_offset", {29'd0, lead_offset}, 32'(off));
    chk("R6 busy after start", {31'd0, busy}, 32'd1);
    for (int n = 0; n < h; n++) begin
      lb = sel + 32'(n) * pt;
      wb = lb & ~32'h7;
      for (int k = 0; k < nw; k++) begin
        exp_a = rev ? wb + 32'((nw - 1 - k) * 8) : wb + 32'(k * 8);
        if (stall && (k % 2 == 0)) begin
          gnt = 1'b0;
          if (poke && !poked) begin start = 1'b1; poked = 1; end
          @(negedge clk);
          start = 1'b0;
          chk("R9 req held in stall", {31'd0, req}, 32'd1);
          chk("R9 addr held in stall", addr, exp_a);
        end
        chk("R1 done low mid-frame", {31'd0, done}, 32'd0);
        chk("R6 lead_offset held", {29'd0, lead_offset}, 32'(off));
        chk("R2 req present", {31'd0, req}, 32'd1);
        if (k == 0) chk("R3 line start", addr, exp_a);
        else if (rev) chk("R5 reverse step", addr, exp_a);
        else chk("R4 forward step", addr, exp_a);
        gnt = 1'b1;
        @(negedge clk);
      end
    end
    gnt = 1'b0;
    chk("R8 done after final grant", {31'd0, done}, 32'd1);
    chk("R8 req low with done", {31'd0, req}, 32'd0);
    chk("R2 no extra words busy low", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
    chk("R8 stays idle", {31'd0, req}, 32'd0);
  endtask

  task automatic bad_setup(input string tag, input logic [31:0] ba, input int cb,
                           input int w, input int h, input bit exp_err);
    @(negedge clk);
    base_a = ba; field_sel = 1'b0; comp_bytes = 3'(cb);
    width_px = PIX_W'(w); height_ln = LINE_W'(h); pitch = 32'h40;
    #1;
    chk({tag, " align_err"}, {31'd0, align_err}, 32'(exp_err));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " no busy"}, {31'd0, busy}, 32'd0);
    chk({tag, " no req"}, {31'd0, req}, 32'd0);
    @(negedge clk);
    chk({tag, " still idle"}, {31'd0, req}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req at reset", {31'd0, req}, 32'd0);
    chk("R1 busy at reset", {31'd0, busy}, 32'd0);
    chk("R1 done at reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {31'd0, req}, 32'd0);

    // R4: forward, field 0, 2 words per line
    run_frame(32'h1000, 32'h9000, 1'b0, 1'b0, 10, 3, 1, 32'h40, 0, 0);
    // R6 R9 R10: field 1 with offset 6, stalls and a start poke while busy
    run_frame(32'h8000, 32'h2006, 1'b1, 1'b0, 5, 2, 2, 32'h100, 1, 1);
    // R5: reverse, 4 words per line
    run_frame(32'h3004, 32'h0, 1'b0, 1'b1, 7, 3, 4, 32'h208, 0, 0);
    // R3 R8: one-word lines, each grant ends a line, last ends frame
    run_frame(32'h4000, 32'h0, 1'b0, 1'b1, 1, 4, 1, 32'h8, 0, 0);
    // R3: pitch not a multiple of 8
    run_frame(32'h0, 32'h5002, 1'b1, 1'b0, 3, 3, 2, 32'h4C, 1, 0);
    // R2: odd span crossing words, reverse with stalls
    run_frame(32'h6002, 32'h0, 1'b0, 1'b1, 9, 2, 2, 32'h80, 1, 0);

    bad_setup("R7 offset 3 with 2-byte", 32'h1003, 2, 4, 2, 1);
    bad_setup("R7 offset 2 with 4-byte", 32'h1002, 4, 4, 2, 1);
    bad_setup("R7 zero comp bytes", 32'h1000, 0, 4, 2, 1);
    bad_setup("R10 zero width", 32'h1000, 1, 0, 2, 0);
    bad_setup("R10 zero height", 32'h1000, 1, 4, 0, 0);

    // the block still works after refusals
    run_frame(32'h7004, 32'h0, 1'b0, 1'b0, 2, 2, 2, 32'h20, 0, 0);

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule